// File: doc/BRIEF.md
# Masked Secondary Target-Address Matcher

This block decides whether a 7-bit address received by an I2C target should be acknowledged against a second, maskable own address. A 32-bit configuration word holds the address, a mask code and an enable. A plain write/read port sets and reads that word.

Each received address arrives with a one-cycle valid strobe. The matcher has no back-pressure: it accepts a strobe on every cycle, strobes may come back to back, and no ready signal exists. One clock after each strobe it presents a registered decision for exactly one cycle. The decision is the ACK/NACK bit plus a raw match flag for debug.

The mask code sets how many low-order address bits are ignored. Whenever any masking is active, the two reserved address groups are refused.

Top module: `sam_matcher`

## Requirements
- R1: After reset the configuration word reads 0, and `dec_valid`, `dec_ack` and `dec_match` are 0.
- R2: The configuration word has three fields. The own address sits in bits 7:1, with word bit k holding address bit k. The mask code sits in bits 10:8. The enable sits in bit 15. Every other bit reads 0, and reads return the stored value combinationally.
- R3: While the stored enable is 1, a write leaves the address and mask fields unchanged, but it still updates the enable. While the enable is 0, a write updates all three fields on the clock edge where `cfg_wr_en` is sampled.
- R4: Every cycle with `addr_valid` high produces `dec_valid` high on the following cycle only. `dec_valid` is low in every cycle that does not follow a strobe.
- R5: Mask code N, for N from 1 to 6, ignores received bits N:1 and compares bits 7:N+1 with the own address. Code 0 compares all seven bits.
- R6: Mask code 7 compares no bits, so every received address matches.
- R7: With a nonzero mask code, a received address whose bits 7:4 are 0000 or 1111 gets `dec_ack` = 0, even when the comparison matches.
- R8: With mask code 0, reserved values are not filtered, so an exact match on such a value is acknowledged.
- R9: While the enable is 0, `dec_ack` is 0 for any received address.
- R10: A strobe in the same cycle as a configuration write is judged against the configuration as it stood before that write.
- R11: `dec_match` reports the masked comparison alone, ignoring the enable and the reserved filter. `dec_ack` equals enable AND match AND NOT (mask code nonzero AND reserved address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write word |
| cfg_rd_data | output | 32 | Current configuration word |
| addr_valid | input | 1 | Received-address strobe, one cycle per address |
| addr_in | input | 7 | Received address, bits 7:1 |
| dec_valid | output | 1 | Decision valid, one cycle after a strobe |
| dec_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| dec_match | output | 1 | Raw masked comparison result |

## Verification
A configuration write and an address strobe can share one cycle. The write may even change the enable or, while the block is disabled, the mask and address. The bench drives both in the same cycle, both directed and at random. It judges the decision with a reference model holding the configuration as it stood before that write, then checks the read-back against the updated model.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int ADDR_W  = 7;
  localparam int MSK_W   = 3;
  localparam int REG_W   = 32;
  localparam int ADDR_LO = 1;
  localparam int MSK_LO  = 8;
  localparam int EN_BIT  = 15;
  localparam int RSV_W   = 4;

  typedef struct packed {
    logic              en;
    logic [MSK_W-1:0]  code;
    logic [ADDR_W:1]   addr;
  } sam_cfg_t;
endpackage

// File: rtl/sam_cfg_reg.sv
module sam_cfg_reg
  import sam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output sam_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data
);
  sam_cfg_t cfg_q;

  // Address and mask are frozen while enabled; enable always writable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.en <= wr_data[EN_BIT];
      if (!cfg_q.en) begin
        cfg_q.addr <= wr_data[ADDR_LO +: ADDR_W];
        cfg_q.code <= wr_data[MSK_LO +: MSK_W];
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[ADDR_LO +: ADDR_W] = cfg_q.addr;
    rd_data[MSK_LO +: MSK_W]   = cfg_q.code;
    rd_data[EN_BIT]            = cfg_q.en;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sam_mask_cmp.sv
module sam_mask_cmp
  import sam_pkg::*;
(
  input  logic [ADDR_W:1]  own,
  input  logic [MSK_W-1:0] code,
  input  logic [ADDR_W:1]  rx,
  output logic             match
);
  logic [ADDR_W:1] hit;

  // Bit g takes part in the comparison only when g exceeds the mask code.
  for (genvar g = 1; g <= ADDR_W; g++) begin : g_bit
    assign hit[g] = (code >= MSK_W'(g)) || (rx[g] == own[g]);
  end

  assign match = &hit;
endmodule

// File: rtl/sam_rsvd_check.sv
module sam_rsvd_check
  import sam_pkg::*;
(
  input  logic [ADDR_W:1]  rx,
  input  logic [MSK_W-1:0] code,
  output logic             block
);
  logic [RSV_W-1:0] top;
  assign top   = rx[ADDR_W -: RSV_W];
  assign block = (code != '0) && ((top == '0) || (top == '1));
endmodule

// File: rtl/sam_matcher.sv
module sam_matcher
  import sam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              addr_valid,
  input  logic [ADDR_W:1]   addr_in,
  output logic              dec_valid,
  output logic              dec_ack,
  output logic              dec_match
);
  sam_cfg_t cfg;
  logic     cmp_hit;
  logic     rsv_block;

  sam_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  sam_mask_cmp u_cmp (
    .own   (cfg.addr),
    .code  (cfg.code),
    .rx    (addr_in),
    .match (cmp_hit)
  );

  sam_rsvd_check u_rsv (
    .rx    (addr_in),
    .code  (cfg.code),
    .block (rsv_block)
  );

  // Decision uses the pre-write configuration because cfg is the register output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_ack   <= 1'b0;
      dec_match <= 1'b0;
    end else begin
      dec_valid <= addr_valid;
      dec_match <= addr_valid && cmp_hit;
      dec_ack   <= addr_valid && cfg.en && cmp_hit && !rsv_block;
    end
  end
endmodule

// File: rtl/sam_matcher_chk.sv
module sam_matcher_chk
  import sam_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [REG_W-1:0]  cfg_wr_data,
  input logic [REG_W-1:0]  cfg_rd_data,
  input logic              addr_valid,
  input logic [ADDR_W:1]   addr_in,
  input logic              dec_valid,
  input logic              dec_ack,
  input logic              dec_match
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> dec_valid);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !dec_valid);
  a_r11_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ack || dec_match) |-> dec_valid);
  a_r3_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_rd_data[EN_BIT]) |=>
      (cfg_rd_data[MSK_LO+MSK_W-1:ADDR_LO] == $past(cfg_rd_data[MSK_LO+MSK_W-1:ADDR_LO])));
  a_r9_disabled_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !cfg_rd_data[EN_BIT]) |=> !dec_ack);
  a_r7_reserved_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cfg_rd_data[MSK_LO +: MSK_W] != '0 &&
     (addr_in[ADDR_W -: RSV_W] == '0 || addr_in[ADDR_W -: RSV_W] == '1)) |=> !dec_ack);
endmodule

bind sam_matcher sam_matcher_chk u_chk (.*);

// File: tb/sam_matcher_tb.sv
module sam_matcher_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        addr_valid = 1'b0;
  logic [7:1]  addr_in = '0;
  logic        dec_valid, dec_ack, dec_match;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       m_en = 0;
  logic [2:0] m_code = 0;
  logic [7:1] m_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sam_matcher u_dut (.*);

  function automatic logic [31:0] m_rd();
    return {16'b0, m_en, 4'b0, m_code, m_addr, 1'b0};
  endfunction

  function automatic logic f_match(logic [2:0] c, logic [7:1] own, logic [7:1] a);
    for (int i = 1; i <= 7; i++)
      if (i > int'(c) && own[i] != a[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic f_ack(logic e, logic [2:0] c, logic [7:1] own, logic [7:1] a);
    logic rsv;
    rsv = (a[7:4] == 4'h0) || (a[7:4] == 4'hF);
    return e && f_match(c, own, a) && !(c != 0 && rsv);
  endfunction

  function automatic logic [31:0] cw(logic e, logic [2:0] c, logic [7:1] a);
    return {16'b0, e, 4'b0, c, a, 1'b0};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus starting and ending at a falling edge.
  task automatic step(bit wr, logic [31:0] wd, bit av, logic [7:1] a, string req);
    logic ev, ea, em;
    cfg_wr_en = wr; cfg_wr_data = wd; addr_valid = av; addr_in = a;
    ev = av;
    em = av && f_match(m_code, m_addr, a);
    ea = av && f_ack(m_en, m_code, m_addr, a);
    if (wr) begin
      if (!m_en) begin m_addr = wd[7:1]; m_code = wd[10:8]; end
      m_en = wd[15];
    end
    @(negedge clk);
    cfg_wr_en = 0; addr_valid = 0;
    chk(dec_valid == ev, {req, " valid R4"}, 32'(dec_valid), 32'(ev));
    chk(dec_ack == ea,   {req, " ack"},      32'(dec_ack),   32'(ea));
    chk(dec_match == em, {req, " match R11"}, 32'(dec_match), 32'(em));
    chk(cfg_rd_data == m_rd(), {req, " readback R2"}, cfg_rd_data, m_rd());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cfg_rd_data == 0, "R1 reg", cfg_rd_data, 0);
    chk(dec_valid == 0 && dec_ack == 0 && dec_match == 0, "R1 outputs",
        {29'b0, dec_valid, dec_ack, dec_match}, 0);
    rst_n = 1;
    @(negedge clk);
    // R9: disabled, configured address 0x52 exact -> NACK
    step(1, cw(0, 0, 7'h52) | 32'hFFFF_0001, 0, 0, "R2 reserved bits");
    step(0, 0, 1, 7'h52, "R9 disabled");
    // R5 code 0 exact and mismatch
    step(1, cw(1, 0, 7'h52), 0, 0, "enable");
    step(0, 0, 1, 7'h52, "R5 exact");
    step(0, 0, 1, 7'h53, "R5 mismatch");
    step(0, 0, 0, 0, "R4 one cycle");
    // R3: writes while enabled leave address/mask
    step(1, cw(1, 3, 7'h11), 0, 0, "R3 frozen");
    step(1, cw(0, 3, 7'h11), 0, 0, "R3 enable writable");
    step(1, cw(1, 3, 7'h52), 0, 0, "R3 update");
    // R5 code 3: bits 3:1 ignored
    step(0, 0, 1, 7'h55, "R5 code3 low bits");
    step(0, 0, 1, 7'h5A, "R5 code3 bit4 differs");
    // R6: code 7 matches all non-reserved
    step(1, cw(0, 7, 7'h00), 0, 0, "cfg");
    step(1, cw(1, 7, 7'h00), 0, 0, "cfg");
    step(0, 0, 1, 7'h3C, "R6 any");
    // R7: reserved refused with nonzero code
    step(0, 0, 1, 7'h05, "R7 low group");
    step(0, 0, 1, 7'h7E, "R7 high group");
    // R8: code 0 exact reserved accepted
    step(1, cw(0, 0, 7'h03), 0, 0, "cfg");
    step(1, cw(1, 0, 7'h03), 0, 0, "cfg");
    step(0, 0, 1, 7'h03, "R8 reserved exact");
    // R10: strobe with disabling write judged on old config
    step(1, cw(0, 0, 7'h03), 1, 7'h03, "R10 same cycle");
    step(1, cw(1, 0, 7'h40), 1, 7'h40, "R10 same cycle enable");
    step(0, 0, 1, 7'h40, "R10 after");
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(($urandom % 4) == 0, r, ($urandom % 3) != 0, 7'($urandom), "random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule